// File: doc/BRIEF.md
# Load Issue Gate with Blocked-Load Tracking

This block sits between a load/store queue and a data-cache port. Each cycle it takes at most one load request and chooses one of three outcomes: present it to the cache, send it back for rescheduling with a machine-check style fault, or refuse it because the cycle's port budget is spent. Uncacheable loads may only reach memory once they are both the oldest load in the queue and at the commit point. Any other uncacheable load is turned back.

When the cache rejects a presented load, the block records that load as blocked. It keeps only the oldest such load. A younger rejected load leaves the record alone. A separate handler input marks the record as handled, and an explicit clear empties it. An accepted locked (load-linked) request sets a sticky lock flag.

The block also decides whether the oldest store may write back this cycle. It keeps a small table in which store address, size and data are recorded by index. Recording a store never raises a fault.

Top module: `load_issue_gate`

## Requirements
- R1: After reset, ports_used, lock_flag, blocked, blocked_handled and blocked_seq all read 0.
- R2: A valid load with ld_uncached=1 is sent only when ld_is_head=1 and ld_at_commit=1. Otherwise, in the same cycle, cache_req_valid=0, resched=1 and mc_fault=1, and no other state changes.
- R3: The effective port count for a cycle is 0 when tick=1 and ports_used otherwise. Every load presented to the cache adds one, whether or not it is accepted. ports_used shows the result from the next cycle.
- R4: A valid load that passes the R2 check while the effective count is at least PORT_LIMIT (default 2) is not presented. port_refused=1 in that cycle, resched=0, and the blocked record does not change.
- R5: A presented load with cache_accept=0 changes nothing in the record when blocked=1, blk_clear=0 and blocked_seq is less than its sequence number (unsigned compare).
- R6: Any other presented load with cache_accept=0 sets blocked=1 and blocked_handled=0 and loads blocked_seq with its sequence number, all visible from the next cycle.
- R7: blk_clear=1 empties the record (blocked=0, blocked_seq=0) before a same-cycle rejection is compared, so that rejection is always recorded. blk_handled_set=1 sets blocked_handled unless a rejection is recorded in the same cycle.
- R8: While blocked=0, blocked_seq reads 0.
- R9: A presented load with ld_locked=1 and cache_accept=1 sets lock_flag from the next cycle. lock_flag stays set until reset. A rejected locked load does not set it.
- R10: sq_will_wb is 1 exactly when sq_head_can_wb=1, sq_head_done=0 and sq_mem_blocked=0, in the same cycle.
- R11: st_wr_en=1 stores st_wr_addr, st_wr_size and st_wr_data at entry st_wr_idx. From the next cycle that entry reads back on the st_rd_* outputs when selected by st_rd_idx. A store write never raises mc_fault or resched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | Start of a new port-budget window |
| ld_valid | input | 1 | Load request present |
| ld_seq | input | SEQ_W | Load sequence number (smaller is older) |
| ld_uncached | input | 1 | Load targets uncacheable space |
| ld_locked | input | 1 | Load-linked request |
| ld_is_head | input | 1 | Load is the oldest in the load queue |
| ld_at_commit | input | 1 | Load is at the commit point |
| cache_req_valid | output | 1 | Request presented to the cache |
| cache_req_seq | output | SEQ_W | Sequence number of the presented request |
| cache_accept | input | 1 | Cache takes the presented request this cycle |
| resched | output | 1 | Load must be rescheduled |
| mc_fault | output | 1 | Machine-check style fault for a misplaced uncacheable load |
| port_refused | output | 1 | Load held back by the port budget |
| ports_used | output | CNT_W | Ports consumed in the current window |
| lock_flag | output | 1 | A locked load has been accepted |
| blk_clear | input | 1 | Empty the blocked-load record |
| blk_handled_set | input | 1 | Mark the blocked load as handled |
| blocked | output | 1 | A memory-rejected load is recorded |
| blocked_handled | output | 1 | The recorded load has been handled |
| blocked_seq | output | SEQ_W | Sequence number of the recorded load, 0 when none |
| sq_head_can_wb | input | 1 | Oldest store is eligible for writeback |
| sq_head_done | input | 1 | Oldest store has already completed |
| sq_mem_blocked | input | 1 | A store is held by the memory system |
| sq_will_wb | output | 1 | Oldest store writes back this cycle |
| st_wr_en | input | 1 | Record store fields |
| st_wr_idx | input | ST_IDX_W | Store entry to write |
| st_wr_addr | input | ADDR_W | Store address |
| st_wr_size | input | SIZE_W | Store size in bytes |
| st_wr_data | input | DATA_W | Store data |
| st_rd_idx | input | ST_IDX_W | Store entry to read |
| st_rd_addr | output | ADDR_W | Address of the selected entry |
| st_rd_size | output | SIZE_W | Size of the selected entry |
| st_rd_data | output | DATA_W | Data of the selected entry |

## Verification
The assertions assume that cache_accept is a same-cycle answer to cache_req_valid. They also assume that blocked_seq is compared as a plain unsigned number, so they do not model sequence wrap. The stimulus draws sequence numbers from a small range, which makes older, younger and equal comparisons frequent without ever wrapping. It drives cache_accept freely, including in cycles with no request, where the block must ignore it. Store reads only select entries the bench has already written, because the table has no reset.

// File: rtl/lig_pkg.sv
package lig_pkg;
  typedef enum logic [1:0] {
    LIG_IDLE    = 2'd0,
    LIG_SEND    = 2'd1,
    LIG_RESCHED = 2'd2,
    LIG_REFUSE  = 2'd3
  } lig_verdict_e;
endpackage

// File: rtl/lig_port_meter.sv
module lig_port_meter #(
  parameter int PORT_LIMIT = 2,
  parameter int CNT_W      = $clog2(PORT_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             issue,
  output logic             room,
  output logic [CNT_W-1:0] used
);
  logic [CNT_W-1:0] eff_cnt;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    eff_cnt = tick ? '0 : used;
    room    = (eff_cnt < CNT_W'(PORT_LIMIT));
    cnt_d   = eff_cnt + CNT_W'(issue);
    cnt_en  = tick | issue;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      used <= '0;
    else if (cnt_en) used <= cnt_d;
  end
endmodule

// File: rtl/lig_block_tracker.sv
module lig_block_tracker #(
  parameter int SEQ_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reject,
  input  logic [SEQ_W-1:0] rej_seq,
  input  logic             clr,
  input  logic             hset,
  output logic             blocked,
  output logic             handled,
  output logic [SEQ_W-1:0] seq
);
  logic             live;
  logic             older_kept;
  logic             record;
  logic             blk_d;
  logic             hnd_d;
  logic [SEQ_W-1:0] seq_d;
  logic             blk_en;
  logic             hnd_en;

  always_comb begin
    live       = blocked & ~clr;
    older_kept = live & (seq < rej_seq);
    record     = reject & ~older_kept;
    blk_d      = blocked;
    seq_d      = seq;
    if (record) begin
      blk_d = 1'b1;
      seq_d = rej_seq;
    end else if (clr) begin
      blk_d = 1'b0;
      seq_d = '0;
    end
    hnd_d  = record ? 1'b0 : 1'b1;
    blk_en = record | clr;
    hnd_en = record | hset;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blocked <= 1'b0;
      seq     <= '0;
    end else if (blk_en) begin
      blocked <= blk_d;
      seq     <= seq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      handled <= 1'b0;
    else if (hnd_en) handled <= hnd_d;
  end
endmodule

// File: rtl/lig_store_table.sv
module lig_store_table #(
  parameter int DEPTH  = 8,
  parameter int IDX_W  = $clog2(DEPTH),
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 4,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [SIZE_W-1:0] wr_size,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [SIZE_W-1:0] rd_size,
  output logic [DATA_W-1:0] rd_data
);
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [SIZE_W-1:0] size_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic ent_en;
    assign ent_en = wr_en & (wr_idx == IDX_W'(e));
    always_ff @(posedge clk) begin
      if (ent_en) begin
        addr_q[e] <= wr_addr;
        size_q[e] <= wr_size;
        data_q[e] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_addr = addr_q[rd_idx];
    rd_size = size_q[rd_idx];
    rd_data = data_q[rd_idx];
  end
endmodule

// File: rtl/load_issue_gate.sv
module load_issue_gate
  import lig_pkg::*;
#(
  parameter int SEQ_W      = 16,
  parameter int PORT_LIMIT = 2,
  parameter int CNT_W      = $clog2(PORT_LIMIT + 1),
  parameter int ST_DEPTH   = 8,
  parameter int ST_IDX_W   = $clog2(ST_DEPTH),
  parameter int ADDR_W     = 32,
  parameter int SIZE_W     = 4,
  parameter int DATA_W     = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                ld_valid,
  input  logic [SEQ_W-1:0]    ld_seq,
  input  logic                ld_uncached,
  input  logic                ld_locked,
  input  logic                ld_is_head,
  input  logic                ld_at_commit,
  output logic                cache_req_valid,
  output logic [SEQ_W-1:0]    cache_req_seq,
  input  logic                cache_accept,
  output logic                resched,
  output logic                mc_fault,
  output logic                port_refused,
  output logic [CNT_W-1:0]    ports_used,
  output logic                lock_flag,
  input  logic                blk_clear,
  input  logic                blk_handled_set,
  output logic                blocked,
  output logic                blocked_handled,
  output logic [SEQ_W-1:0]    blocked_seq,
  input  logic                sq_head_can_wb,
  input  logic                sq_head_done,
  input  logic                sq_mem_blocked,
  output logic                sq_will_wb,
  input  logic                st_wr_en,
  input  logic [ST_IDX_W-1:0] st_wr_idx,
  input  logic [ADDR_W-1:0]   st_wr_addr,
  input  logic [SIZE_W-1:0]   st_wr_size,
  input  logic [DATA_W-1:0]   st_wr_data,
  input  logic [ST_IDX_W-1:0] st_rd_idx,
  output logic [ADDR_W-1:0]   st_rd_addr,
  output logic [SIZE_W-1:0]   st_rd_size,
  output logic [DATA_W-1:0]   st_rd_data
);
  logic         rst_meta_n;
  logic         rst_sync_n;
  logic         room;
  logic         issue;
  logic         reject;
  logic         lock_set;
  lig_verdict_e verdict;

  // reset: asserted at once, released over two flops
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  // verdict: misplaced uncacheable first, then port budget
  always_comb begin
    verdict = LIG_IDLE;
    if (ld_valid) begin
      if (ld_uncached && !(ld_is_head && ld_at_commit)) verdict = LIG_RESCHED;
      else if (!room)                                   verdict = LIG_REFUSE;
      else                                              verdict = LIG_SEND;
    end
    issue           = (verdict == LIG_SEND);
    cache_req_valid = issue;
    cache_req_seq   = ld_seq;
    resched         = (verdict == LIG_RESCHED);
    mc_fault        = (verdict == LIG_RESCHED);
    port_refused    = (verdict == LIG_REFUSE);
    reject          = issue & ~cache_accept;
    lock_set        = issue & cache_accept & ld_locked;
    sq_will_wb      = sq_head_can_wb & ~sq_head_done & ~sq_mem_blocked;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   lock_flag <= 1'b0;
    else if (lock_set) lock_flag <= 1'b1;
  end

  lig_port_meter #(.PORT_LIMIT(PORT_LIMIT), .CNT_W(CNT_W)) u_meter (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .tick  (tick),
    .issue (issue),
    .room  (room),
    .used  (ports_used)
  );

  lig_block_tracker #(.SEQ_W(SEQ_W)) u_track (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .reject  (reject),
    .rej_seq (ld_seq),
    .clr     (blk_clear),
    .hset    (blk_handled_set),
    .blocked (blocked),
    .handled (blocked_handled),
    .seq     (blocked_seq)
  );

  lig_store_table #(
    .DEPTH(ST_DEPTH), .IDX_W(ST_IDX_W), .ADDR_W(ADDR_W),
    .SIZE_W(SIZE_W), .DATA_W(DATA_W)
  ) u_stab (
    .clk     (clk),
    .wr_en   (st_wr_en),
    .wr_idx  (st_wr_idx),
    .wr_addr (st_wr_addr),
    .wr_size (st_wr_size),
    .wr_data (st_wr_data),
    .rd_idx  (st_rd_idx),
    .rd_addr (st_rd_addr),
    .rd_size (st_rd_size),
    .rd_data (st_rd_data)
  );
endmodule

// File: rtl/lig_checker.sv
module lig_checker #(
  parameter int SEQ_W      = 16,
  parameter int PORT_LIMIT = 2,
  parameter int CNT_W      = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ld_valid,
  input logic             ld_uncached,
  input logic             ld_is_head,
  input logic             ld_at_commit,
  input logic             cache_req_valid,
  input logic [SEQ_W-1:0] cache_req_seq,
  input logic             cache_accept,
  input logic             resched,
  input logic             mc_fault,
  input logic             port_refused,
  input logic [CNT_W-1:0] ports_used,
  input logic             lock_flag,
  input logic             blk_clear,
  input logic             blocked,
  input logic             blocked_handled,
  input logic [SEQ_W-1:0] blocked_seq,
  input logic             sq_head_can_wb,
  input logic             sq_head_done,
  input logic             sq_mem_blocked,
  input logic             sq_will_wb
);
  // R2
  uncached_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_uncached && !(ld_is_head && ld_at_commit))
      |-> (!cache_req_valid && resched && mc_fault));

  // R4
  refuse_no_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
    port_refused |-> (!cache_req_valid && !resched));

  // R3
  port_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ports_used <= CNT_W'(PORT_LIMIT));

  // R5
  older_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cache_req_valid && !cache_accept && blocked && !blk_clear &&
     (blocked_seq < cache_req_seq))
      |=> (blocked && $stable(blocked_seq)));

  // R6
  reject_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cache_req_valid && !cache_accept &&
     !(blocked && !blk_clear && (blocked_seq < cache_req_seq)))
      |=> (blocked && !blocked_handled && (blocked_seq == $past(cache_req_seq))));

  // R8
  idle_seq_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !blocked |-> (blocked_seq == '0));

  // R9
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_flag |=> lock_flag);

  // R10
  store_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sq_will_wb |-> (sq_head_can_wb && !sq_head_done && !sq_mem_blocked));
endmodule

bind load_issue_gate lig_checker #(
  .SEQ_W(SEQ_W), .PORT_LIMIT(PORT_LIMIT), .CNT_W(CNT_W)
) u_lig_chk (
  .clk             (clk),
  .rst_n           (rst_sync_n),
  .ld_valid        (ld_valid),
  .ld_uncached     (ld_uncached),
  .ld_is_head      (ld_is_head),
  .ld_at_commit    (ld_at_commit),
  .cache_req_valid (cache_req_valid),
  .cache_req_seq   (cache_req_seq),
  .cache_accept    (cache_accept),
  .resched         (resched),
  .mc_fault        (mc_fault),
  .port_refused    (port_refused),
  .ports_used      (ports_used),
  .lock_flag       (lock_flag),
  .blk_clear       (blk_clear),
  .blocked         (blocked),
  .blocked_handled (blocked_handled),
  .blocked_seq     (blocked_seq),
  .sq_head_can_wb  (sq_head_can_wb),
  .sq_head_done    (sq_head_done),
  .sq_mem_blocked  (sq_mem_blocked),
  .sq_will_wb      (sq_will_wb)
);

// File: tb/tb_load_issue_gate.sv
module tb_load_issue_gate;
  localparam int SEQ_W = 16, LIM = 2, CNT_W = $clog2(LIM + 1);
  localparam int SD = 8, SI = 3, AW = 32, SW = 4, DW = 64;

  logic clk = 1'b0;
  logic rst_n;
  logic tick, ld_valid, ld_uncached, ld_locked, ld_is_head, ld_at_commit;
  logic [SEQ_W-1:0] ld_seq;
  logic cache_req_valid, cache_accept, resched, mc_fault, port_refused, lock_flag;
  logic [SEQ_W-1:0] cache_req_seq, blocked_seq;
  logic [CNT_W-1:0] ports_used;
  logic blk_clear, blk_handled_set, blocked, blocked_handled;
  logic sq_head_can_wb, sq_head_done, sq_mem_blocked, sq_will_wb;
  logic st_wr_en;
  logic [SI-1:0] st_wr_idx, st_rd_idx;
  logic [AW-1:0] st_wr_addr, st_rd_addr;
  logic [SW-1:0] st_wr_size, st_rd_size;
  logic [DW-1:0] st_wr_data, st_rd_data;

  int n_chk = 0, n_bad = 0;

  // bench model
  int unsigned      m_cnt;
  logic             m_blk, m_hnd, m_lock;
  logic [SEQ_W-1:0] m_seq;
  logic [AW-1:0]    m_addr [SD];
  logic [SW-1:0]    m_size [SD];
  logic [DW-1:0]    m_data [SD];

  always #10 clk = ~clk;

  load_issue_gate dut (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic f_unc_bad();
    return ld_valid & ld_uncached & ~(ld_is_head & ld_at_commit);
  endfunction

  function automatic int unsigned f_eff();
    return tick ? 0 : m_cnt;
  endfunction

  function automatic logic f_refuse();
    return ld_valid & ~f_unc_bad() & (f_eff() >= LIM);
  endfunction

  function automatic logic f_issue();
    return ld_valid & ~f_unc_bad() & ~f_refuse();
  endfunction

  task automatic idle_in();
    tick = 1'b0; ld_valid = 1'b0; ld_seq = '0; ld_uncached = 1'b0; ld_locked = 1'b0;
    ld_is_head = 1'b0; ld_at_commit = 1'b0; cache_accept = 1'b0;
    blk_clear = 1'b0; blk_handled_set = 1'b0;
    sq_head_can_wb = 1'b0; sq_head_done = 1'b0; sq_mem_blocked = 1'b0;
    st_wr_en = 1'b0; st_wr_idx = '0; st_wr_addr = '0; st_wr_size = '0; st_wr_data = '0;
    st_rd_idx = '0;
  endtask

  // one cycle: inputs already set at a negedge
  task automatic cyc(input logic rd_ok);
    logic iss, rej, keep, rec;
    #2;
    iss = f_issue();
    chk("R3 req_valid", cache_req_valid, iss);
    if (iss) chk("R3 req_seq", cache_req_seq, ld_seq);
    chk("R2 resched", resched, f_unc_bad());
    chk("R2 mc_fault", mc_fault, f_unc_bad());
    chk("R4 refused", port_refused, f_refuse());
    chk("R10 will_wb", sq_will_wb, sq_head_can_wb & ~sq_head_done & ~sq_mem_blocked);
    if (rd_ok) begin
      chk("R11 rd_addr", st_rd_addr, m_addr[st_rd_idx]);
      chk("R11 rd_size", st_rd_size, m_size[st_rd_idx]);
      chk("R11 rd_data", st_rd_data, m_data[st_rd_idx]);
    end
    // next state
    rej  = iss & ~cache_accept;
    keep = m_blk & ~blk_clear & (m_seq < ld_seq);
    rec  = rej & ~keep;
    m_cnt = f_eff() + (iss ? 1 : 0);
    if (rec) begin m_blk = 1'b1; m_seq = ld_seq; m_hnd = 1'b0; end
    else begin
      if (blk_clear) begin m_blk = 1'b0; m_seq = '0; end
      if (blk_handled_set) m_hnd = 1'b1;
    end
    if (iss & cache_accept & ld_locked) m_lock = 1'b1;
    if (st_wr_en) begin
      m_addr[st_wr_idx] = st_wr_addr; m_size[st_wr_idx] = st_wr_size;
      m_data[st_wr_idx] = st_wr_data;
    end
    @(negedge clk);
    chk("R3 ports_used", ports_used, m_cnt);
    chk(keep && rej ? "R5 seq" : "R6 seq", blocked_seq, m_seq);
    chk("R6 blocked", blocked, m_blk);
    chk("R7 handled", blocked_handled, m_hnd);
    chk("R9 lock", lock_flag, m_lock);
    if (!blocked) chk("R8 seq zero", blocked_seq, 0);
  endtask

  task automatic do_reset();
    idle_in();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    m_cnt = 0; m_blk = 0; m_hnd = 0; m_lock = 0; m_seq = '0;
    // R1
    chk("R1 ports_used", ports_used, 0);
    chk("R1 lock", lock_flag, 0);
    chk("R1 blocked", blocked, 0);
    chk("R1 handled", blocked_handled, 0);
    chk("R1 seq", blocked_seq, 0);
  endtask

  task automatic load(input int s, input logic acc, input logic tk);
    idle_in();
    ld_valid = 1'b1; ld_seq = SEQ_W'(s); cache_accept = acc; tick = tk;
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    idle_in();
    rst_n = 1'b0;
    @(negedge clk);
    do_reset();

    // R11: fill the store table, no fault from store writes
    for (int i = 0; i < SD; i++) begin
      idle_in();
      st_wr_en = 1'b1; st_wr_idx = SI'(i);
      st_wr_addr = AW'(32'h1000 + i * 8); st_wr_size = SW'(1 << (i % 4));
      st_wr_data = {32'hA5A5_0000, 32'(i)};
      cyc(1'b0);
    end
    for (int i = 0; i < SD; i++) begin idle_in(); st_rd_idx = SI'(i); cyc(1'b1); end

    // R2: uncached not at head / not at commit / both
    load(3, 1'b1, 1'b1); ld_uncached = 1'b1; ld_is_head = 1'b1; cyc(1'b1);
    load(3, 1'b1, 1'b1); ld_uncached = 1'b1; ld_at_commit = 1'b1; cyc(1'b1);
    load(3, 1'b1, 1'b1); ld_uncached = 1'b1; ld_is_head = 1'b1; ld_at_commit = 1'b1; cyc(1'b1);

    // R4: budget exhausted without tick; refused load leaves record alone
    load(5, 1'b0, 1'b1); cyc(1'b1);         // R6 record seq 5
    load(6, 1'b0, 1'b0); cyc(1'b1);         // R5 younger, kept
    load(2, 1'b0, 1'b0); cyc(1'b1);         // R4 refused, record still 5
    load(2, 1'b0, 1'b1); cyc(1'b1);         // R6 older replaces
    // R7: handled, then clear with same-cycle younger reject
    idle_in(); blk_handled_set = 1'b1; cyc(1'b1);
    load(9, 1'b0, 1'b1); blk_clear = 1'b1; cyc(1'b1);
    idle_in(); blk_clear = 1'b1; cyc(1'b1);  // R8
    // R9: rejected locked then accepted locked
    load(1, 1'b0, 1'b1); ld_locked = 1'b1; cyc(1'b1);
    load(1, 1'b1, 1'b1); ld_locked = 1'b1; cyc(1'b1);
    idle_in(); cyc(1'b1);
    do_reset();

    // random mix
    for (int n = 0; n < 3000; n++) begin
      idle_in();
      tick = ($urandom % 10) < 6;
      ld_valid = ($urandom % 10) < 7;
      ld_seq = SEQ_W'($urandom % 16);
      ld_uncached = ($urandom % 8) == 0;
      ld_is_head = $urandom % 2; ld_at_commit = $urandom % 2;
      ld_locked = ($urandom % 6) == 0;
      cache_accept = ($urandom % 10) < 6;
      blk_clear = ($urandom % 10) == 0;
      blk_handled_set = ($urandom % 10) == 0;
      sq_head_can_wb = $urandom % 2; sq_head_done = $urandom % 2;
      sq_mem_blocked = $urandom % 2;
      st_wr_en = $urandom % 2; st_wr_idx = SI'($urandom);
      st_wr_addr = $urandom; st_wr_size = SW'($urandom);
      st_wr_data = {$urandom, $urandom};
      st_rd_idx = SI'($urandom);
      cyc(1'b1);
      if (n == 1500) do_reset();
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule